// File: doc/BRIEF.md
# Receive Overhead Serial Output Interface

This block takes the overhead captured from each received E3 frame, presented as a parallel word of seven bytes, and sends it out one bit per interface clock on a serial data pin. A one-period start-of-frame strobe marks the first bit of each frame. The interface clock is forwarded as a free-running companion output. Serial data and strobe change on the falling edge of that clock, so an attached data link device can sample both on the rising edge.

A frame-ready pulse copies the parallel word into a holding register. The sequencer moves the held word into its own shift register only when it is idle or when it has just sent the last bit of the current frame. Frames therefore follow one another with no gap and are never mixed. If no word is waiting when a frame ends, the data pin rests at 0 and the strobe stays low. The block has no enable and cannot tristate its outputs.

Top module: `oh_serial_tx`

## Requirements
- R1: `ser_data` and `sof_strobe` change only on a falling edge of `clk`. They hold steady from one falling edge to the next, including through the high phase.
- R2: `sof_strobe` is high for exactly one clock period, and only while the first overhead bit of a frame is on `ser_data`. Two strobes are at least 56 periods apart.
- R3: Each frame is sent starting at `ovh_bytes[55]` and ending at `ovh_bytes[0]`. Bits [55:48] hold the first overhead byte (FA1) and bits [47:40] hold the second (FA2), so each byte goes out most significant bit first.
- R4: When a word is waiting at the end of a frame, its first bit follows the previous frame's last bit in the very next period, with no idle period between them.
- R5: A word loaded while a frame is being sent does not change any remaining bit of that frame.
- R6: While no frame is being sent, `ser_data` is 0 and `sof_strobe` is 0.
- R7: From idle, a `ovh_load` sampled high on rising edge N gives a strobe first visible after rising edge N+2. It is not visible after rising edge N+1.
- R8: A second load that arrives while a word is still waiting replaces the waiting word. The replaced word is never sent.
- R9: `rst` (synchronous, active high) stops any frame in progress, discards any waiting word, and forces `ser_data` and `sof_strobe` to 0.
- R10: `ser_clk` follows `clk` at all times, including during reset and idle. No input can stop it or disable the data output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| ovh_load | input | 1 | Frame-ready pulse; captures `ovh_bytes` |
| ovh_bytes | input | 56 | Overhead bytes of one frame, first byte in bits [55:48] |
| ser_clk | output | 1 | Free-running copy of the interface clock |
| ser_data | output | 1 | Serial overhead bit, updated on falling edge |
| sof_strobe | output | 1 | High for the period carrying a frame's first bit |

## Verification
A load pulse sampled at rising edge N passes through the holding register at N. The sequencer takes the word at N+1, and the falling-edge output stage presents it half a period later, so the strobe first appears in the sample taken just after edge N+2. After that, one new bit is due at every later rising edge. The bench drives inputs 1 ns after a rising edge and samples outputs 1 ns after each rising edge, with a second look at 2 ns to confirm the value held through the high phase. This keeps every sample clear of both clock edges. A scoreboard queue holds each expected frame. The monitor pops a frame when the strobe appears and then compares one bit per period; in the gaps it expects zeros.

// File: rtl/oh_ser_pkg.sv
package oh_ser_pkg;
  typedef enum logic [0:0] {
    SEQ_IDLE  = 1'b0,
    SEQ_SHIFT = 1'b1
  } seq_state_e;
endpackage

// File: rtl/oh_frame_hold.sv
module oh_frame_hold #(
  parameter int WIDTH = 56
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             take_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] data_o
);
  logic             valid_q;
  logic [WIDTH-1:0] data_q;

  // A new load wins over a take on the same edge: the word just taken
  // was the old one, and the new one is left waiting.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
    end else if (load_i) begin
      valid_q <= 1'b1;
    end else if (take_i) begin
      valid_q <= 1'b0;
    end
  end

  // Data register has no reset, so it can map onto plain fabric storage.
  always_ff @(posedge clk) begin
    if (load_i) begin
      data_q <= data_i;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
endmodule

// File: rtl/oh_bit_seq.sv
module oh_bit_seq
  import oh_ser_pkg::*;
#(
  parameter int WIDTH = 56
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pend_valid_i,
  input  logic [WIDTH-1:0] pend_data_i,
  output logic             take_o,
  output logic             active_o,
  output logic             first_o,
  output logic             bit_o,
  output logic [WIDTH-1:0] shadow_o
);
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  seq_state_e       state_q;
  logic [CW-1:0]    cnt_q;
  logic [WIDTH-1:0] shadow_q;
  logic             at_last;
  logic             take;

  assign at_last = (state_q == SEQ_SHIFT) && (cnt_q == LAST);
  assign take    = pend_valid_i && ((state_q == SEQ_IDLE) || at_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else if (take) begin
      state_q <= SEQ_SHIFT;
      cnt_q   <= '0;
    end else if (state_q == SEQ_SHIFT) begin
      if (at_last) begin
        state_q <= SEQ_IDLE;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // Shift register: loaded whole, then shifted toward the MSB each period.
  always_ff @(posedge clk) begin
    if (take) begin
      shadow_q <= pend_data_i;
    end else if (state_q == SEQ_SHIFT) begin
      shadow_q <= shadow_q << 1;
    end
  end

  assign take_o   = take;
  assign active_o = (state_q == SEQ_SHIFT);
  assign first_o  = (state_q == SEQ_SHIFT) && (cnt_q == '0);
  assign bit_o    = shadow_q[WIDTH-1];
  assign shadow_o = shadow_q;
endmodule

// File: rtl/oh_neg_out.sv
module oh_neg_out (
  input  logic clk,
  input  logic rst,
  input  logic active_i,
  input  logic first_i,
  input  logic bit_i,
  output logic data_o,
  output logic sof_o
);
  // Launch on the falling edge so the far end can capture on the rising one.
  always_ff @(negedge clk) begin
    if (rst) begin
      data_o <= 1'b0;
      sof_o  <= 1'b0;
    end else begin
      data_o <= active_i & bit_i;
      sof_o  <= first_i;
    end
  end
endmodule

// File: rtl/oh_serial_tx.sv
module oh_serial_tx #(
  parameter int OH_BYTES = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ovh_load,
  input  logic [8*OH_BYTES-1:0] ovh_bytes,
  output logic                  ser_clk,
  output logic                  ser_data,
  output logic                  sof_strobe
);
  localparam int FRAME_BITS = 8 * OH_BYTES;

  logic                  hold_valid;
  logic [FRAME_BITS-1:0] hold_data;
  logic                  seq_take;
  logic                  seq_active;
  logic                  seq_first;
  logic                  seq_bit;
  logic [FRAME_BITS-1:0] seq_shadow;

  assign ser_clk = clk;

  oh_frame_hold #(.WIDTH(FRAME_BITS)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .load_i  (ovh_load),
    .data_i  (ovh_bytes),
    .take_i  (seq_take),
    .valid_o (hold_valid),
    .data_o  (hold_data)
  );

  oh_bit_seq #(.WIDTH(FRAME_BITS)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .pend_valid_i (hold_valid),
    .pend_data_i  (hold_data),
    .take_o       (seq_take),
    .active_o     (seq_active),
    .first_o      (seq_first),
    .bit_o        (seq_bit),
    .shadow_o     (seq_shadow)
  );

  oh_neg_out u_out (
    .clk      (clk),
    .rst      (rst),
    .active_i (seq_active),
    .first_i  (seq_first),
    .bit_i    (seq_bit),
    .data_o   (ser_data),
    .sof_o    (sof_strobe)
  );
endmodule

// File: rtl/oh_serial_tx_chk.sv
module oh_serial_tx_chk #(
  parameter int FRAME_BITS = 56
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  ser_data,
  input logic                  sof_strobe,
  input logic                  active,
  input logic                  take,
  input logic [FRAME_BITS-1:0] shadow
);
  logic [15:0] since_sof;
  logic        seen_sof;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_sof <= '0;
      seen_sof  <= 1'b0;
    end else if (sof_strobe) begin
      since_sof <= 16'd1;
      seen_sof  <= 1'b1;
    end else if (since_sof != 16'hFFFF) begin
      since_sof <= since_sof + 16'd1;
    end
  end

  AST_SOF_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sof_strobe |=> !sof_strobe); // R2

  AST_SOF_SPACING: assert property (@(posedge clk) disable iff (rst)
    (sof_strobe && seen_sof) |-> (since_sof >= 16'(FRAME_BITS))); // R2

  AST_SOF_WITH_FRAME: assert property (@(posedge clk) disable iff (rst)
    sof_strobe |-> active); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !active |-> (!ser_data && !sof_strobe)); // R6

  AST_NO_TEAR: assert property (@(posedge clk) disable iff (rst)
    ($past(active) && !$past(take)) |-> (shadow == ($past(shadow) << 1))); // R5

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!ser_data && !sof_strobe)); // R9
endmodule

bind oh_serial_tx oh_serial_tx_chk #(.FRAME_BITS(FRAME_BITS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ser_data   (ser_data),
  .sof_strobe (sof_strobe),
  .active     (seq_active),
  .take       (seq_take),
  .shadow     (seq_shadow)
);

// File: tb/oh_serial_tx_test.sv
`timescale 1ns/100ps
module oh_serial_tx_test;
  localparam int NB = 56;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ovh_load = 1'b0;
  logic [NB-1:0] ovh_bytes = '0;
  logic          ser_clk;
  logic          ser_data;
  logic          sof_strobe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [NB-1:0] exp_q[$];
  logic [NB-1:0] cur;
  int  idx = 0;
  bit  in_frame = 1'b0;
  int  gap = 0;
  int  last_gap = 0;
  int  frames_seen = 0;

  always #2.5 clk = ~clk;

  oh_serial_tx uut (
    .clk        (clk),
    .rst        (rst),
    .ovh_load   (ovh_load),
    .ovh_bytes  (ovh_bytes),
    .ser_clk    (ser_clk),
    .ser_data   (ser_data),
    .sof_strobe (sof_strobe)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic load_frame(input logic [NB-1:0] f, input bit replace);
    @(posedge clk); #1;
    ovh_bytes = f;
    ovh_load  = 1'b1;
    if (replace) void'(exp_q.pop_back());
    exp_q.push_back(f);
    @(posedge clk); #1;
    ovh_load = 1'b0;
  endtask

  task automatic wait_drain();
    while (exp_q.size() != 0 || in_frame) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  // Scoreboard monitor: one sample just after every rising edge
  always begin
    @(posedge clk); #1;
    chk(ser_clk === 1'b1, "R10 clk-high", 64'(ser_clk), 64'd1);
    if (rst) begin
      in_frame = 1'b0;
      idx = 0;
      gap = 0;
    end else begin
      logic d1;
      d1 = ser_data;
      if (sof_strobe) begin
        chk(!in_frame, "R2 strobe mid-frame", 64'(idx), 64'd56);
        chk(exp_q.size() != 0, "R8 R9 unexpected frame", 64'(exp_q.size()), 64'd1);
        if (exp_q.size() != 0) cur = exp_q.pop_front();
        idx = 0;
        last_gap = gap;
        gap = 0;
        in_frame = 1'b1;
        frames_seen++;
      end
      if (in_frame) begin
        chk(ser_data === cur[NB-1-idx], "R3 R5 bit value", 64'(ser_data),
            64'(cur[NB-1-idx]));
        idx++;
        if (idx == NB) in_frame = 1'b0;
      end else begin
        gap++;
        chk(ser_data === 1'b0 && sof_strobe === 1'b0, "R6 idle outputs",
            {62'd0, ser_data, sof_strobe}, 64'd0);
      end
      #1;
      chk(ser_data === d1, "R1 data steady in high phase", 64'(ser_data), 64'(d1));
    end
  end

  always begin
    @(negedge clk); #1;
    chk(ser_clk === 1'b0, "R10 clk-low", 64'(ser_clk), 64'd0);
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seen0;
    repeat (3) @(posedge clk);
    #1;
    chk(ser_data === 1'b0 && sof_strobe === 1'b0, "R9 reset outputs",
        {62'd0, ser_data, sof_strobe}, 64'd0);
    @(posedge clk); #1;
    rst = 1'b0;
    repeat (5) @(posedge clk);

    // R7 latency from idle, R3 order
    load_frame(56'hA53C0FF0817EC3, 1'b0);
    @(posedge clk); #1.5;
    chk(sof_strobe === 1'b0, "R7 strobe too early", 64'(sof_strobe), 64'd0);
    @(posedge clk); #1.5;
    chk(sof_strobe === 1'b1, "R7 strobe at edge N+2", 64'(sof_strobe), 64'd1);
    wait_drain();

    // R8 replace waiting word, R4 back-to-back, R5 no tearing
    load_frame(56'h0123456789ABCD, 1'b0);
    repeat (4) @(posedge clk);
    load_frame(56'hDEADBEEFCAFE01, 1'b0);
    load_frame(56'h5A5A5A5A5A5A5A, 1'b1);
    wait_drain();
    chk(last_gap == 0, "R4 no idle between frames", 64'(last_gap), 64'd0);
    chk(frames_seen == 3, "R8 replaced word dropped", 64'(frames_seen), 64'd3);

    // Edge patterns: all ones, all zeros, alternating, back to back
    load_frame({NB{1'b1}}, 1'b0);
    repeat (10) @(posedge clk);
    load_frame({NB{1'b0}}, 1'b0);
    repeat (60) @(posedge clk);
    load_frame({28{2'b10}}, 1'b0);
    wait_drain();
    chk(frames_seen == 6, "R2 one strobe per frame", 64'(frames_seen), 64'd6);

    // R9 reset mid-frame discards current and waiting words
    load_frame(56'hFEDCBA98765432, 1'b0);
    repeat (5) @(posedge clk);
    load_frame(56'h13579BDF02468A, 1'b0);
    repeat (5) @(posedge clk);
    #1 rst = 1'b1;
    exp_q.delete();
    repeat (2) @(posedge clk);
    #1.5;
    chk(ser_data === 1'b0 && sof_strobe === 1'b0, "R9 outputs in reset",
        {62'd0, ser_data, sof_strobe}, 64'd0);
    rst = 1'b0;
    seen0 = frames_seen;
    repeat (80) @(posedge clk);
    chk(frames_seen == seen0, "R9 waiting word discarded", 64'(frames_seen),
        64'(seen0));

    // Recovery after reset
    load_frame(56'h00FF00FF00FF80, 1'b0);
    wait_drain();
    chk(frames_seen == seen0 + 1, "R9 resumes after reset", 64'(frames_seen),
        64'(seen0 + 1));
    chk(exp_q.size() == 0, "R4 all expected frames sent", 64'(exp_q.size()), 64'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule